// File: doc/BRIEF.md
# Transmit Test Pattern Source

This block feeds a four-level FSK modulator with its stream of dibits. A 4-bit mode code chooses where the bits come from. In calibration mode the block loops one of four fixed byte patterns, chosen by a 2-bit select. In pseudo-random mode it loops a 511-bit maximal-length sequence. In data mode it takes bytes from a transmit FIFO, which the host loads, through a valid/ready byte port. Every byte leaves most-significant dibit first, one dibit for each pulse of the symbol strobe. Each dibit comes with a signed symbol-level tag.

The modulator sets the pace by pulsing `sym_stb_i`. Each accepted strobe produces one registered dibit, and `sym_valid_o` marks it high for one cycle. The output side has no back-pressure, because the strobe itself is the request. On the FIFO side a byte moves when `fifo_ready_o` and `fifo_valid_i` are high in the same cycle. `fifo_ready_o` rises only on a strobe that falls on a byte boundary while data mode is selected. It does not wait for `fifo_valid_i`. The FIFO must keep `fifo_data_i` stable while it holds `fifo_valid_i` high.

Top module: `tx_pattern_src`

## Requirements
- R1: After reset, `sym_valid_o`, `underrun_o` and `fifo_ready_o` are low, and the first strobe falls on a byte boundary.
- R2: While the mode code is 0000 (sleep), or any code other than 1001, 1010 or 1011, a strobe on a byte boundary produces no symbol and takes nothing from the FIFO.
- R3: Each strobe that produces a symbol raises `sym_valid_o` in the following cycle. The dibits of a byte appear in the order bits [7:6], [5:4], [3:2], [1:0].
- R4: `level_o` tags every valid dibit as follows: 01 is +3, 00 is +1, 10 is -1, 11 is -3.
- R5: Mode 1001 with select 0 loops the byte 0x5F.
- R6: Mode 1001 with select 1 loops 0x55 0x55 0x55 0x55 0xFF 0xFF 0xFF 0xFF, which gives sixteen +3 symbols and then sixteen -3 symbols.
- R7: Mode 1001 with select 2 loops 0x55, which gives a steady run of +3 symbols.
- R8: Mode 1001 with select 3 loops the six bytes 0x7F 0x7D 0x5D 0xD5 0x7D 0xFD.
- R9: Mode 1010 sends the sequence of x^9+x^5+1. The register is set to all ones on entry to the mode. For each output bit the feedback bit s[8]^s[4] is sent and also shifted into s[0]. The sequence repeats every 511 bits.
- R10: Mode 1011 sends FIFO bytes in the order they were loaded. Bytes loaded in another mode stay in the FIFO until data mode takes them.
- R11: If no byte is valid when data mode needs one, the block sends a single dibit 00 and stays on the byte boundary. `underrun_o` then sets and stays high until `underrun_clr_i` is pulsed. A new underrun in the same cycle wins over the clear.
- R12: A change of mode or select that arrives in the middle of a byte takes effect only at the next byte boundary. A change of mode, or of select within calibration mode, restarts the pattern at its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 4 | Operating mode code |
| pat_sel_i | input | 2 | Calibration pattern select |
| sym_stb_i | input | 1 | Symbol strobe from the modulator |
| fifo_data_i | input | 8 | Byte offered by the transmit FIFO |
| fifo_valid_i | input | 1 | FIFO has a byte |
| fifo_ready_o | output | 1 | Block takes the offered byte this cycle |
| underrun_clr_i | input | 1 | Clears the underrun flag |
| dibit_o | output | 2 | Current transmit dibit |
| level_o | output | 3 | Signed symbol level of `dibit_o` |
| sym_valid_o | output | 1 | A new dibit is presented |
| underrun_o | output | 1 | Sticky FIFO underrun flag |

## Verification
The bench uses the default parameters: an 8-bit byte, 2-bit dibits, and a 9-stage register with its tap at stage 5. Under these values a 64-byte run of the pseudo-random mode passes the 511-bit wrap, and every calibration pattern, including the 8-byte and 6-byte loops, wraps at least once. A select change made halfway through a byte shows the deferred restart. An empty FIFO in data mode shows the fill symbol, the sticky flag and the clear.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [3:0] {
    MODE_SLEEP = 4'b0000,
    MODE_SETUP = 4'b1001,
    MODE_PRBS  = 4'b1010,
    MODE_DATA  = 4'b1011
  } tx_mode_e;

  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned DIBIT_W      = 2;
  localparam int unsigned SYM_PER_BYTE = BYTE_W / DIBIT_W;
  localparam int unsigned LVL_W        = 3;
endpackage

// File: rtl/tps_level_map.sv
module tps_level_map #(
  parameter int unsigned DIBIT_W = 2,
  parameter int unsigned LVL_W   = 3
) (
  input  logic [DIBIT_W-1:0]      dibit_i,
  output logic signed [LVL_W-1:0] level_o
);
  always_comb begin
    unique case (dibit_i)
      2'b01:   level_o = LVL_W'(3);
      2'b00:   level_o = LVL_W'(1);
      2'b10:   level_o = -LVL_W'(1);
      default: level_o = -LVL_W'(3);
    endcase
  end
endmodule

// File: rtl/tps_pattern_gen.sv
module tps_pattern_gen #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel_i,
  input  logic              restart_i,
  input  logic              advance_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [IDX_W-1:0] idx_q, idx_eff, idx_nxt;
  int unsigned      len;

  function automatic logic [7:0] pat_byte(input logic [1:0] s, input logic [IDX_W-1:0] i);
    logic [7:0] b;
    case (s)
      2'd0: b = 8'h5F;
      2'd1: b = (i < IDX_W'(4)) ? 8'h55 : 8'hFF;
      2'd2: b = 8'h55;
      default: begin
        case (i)
          IDX_W'(0): b = 8'h7F;
          IDX_W'(1): b = 8'h7D;
          IDX_W'(2): b = 8'h5D;
          IDX_W'(3): b = 8'hD5;
          IDX_W'(4): b = 8'h7D;
          default:   b = 8'hFD;
        endcase
      end
    endcase
    return b;
  endfunction

  always_comb begin
    case (sel_i)
      2'd1:    len = 8;
      2'd3:    len = 6;
      default: len = 1;
    endcase
    idx_eff = restart_i ? '0 : idx_q;
    byte_o  = BYTE_W'(pat_byte(sel_i, idx_eff));
    idx_nxt = (32'(idx_eff) + 1 >= len) ? '0 : idx_eff + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idx_q <= '0;
    else if (advance_i) idx_q <= idx_nxt;
  end

  // A one-byte pattern never leaves its first entry
  p_single_byte_pat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    advance_i && (sel_i == 2'd0 || sel_i == 2'd2) |=> idx_q == '0);

  // The six-byte loop wraps after its last byte
  p_six_byte_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    advance_i && !restart_i && sel_i == 2'd3 && idx_q == IDX_W'(5) |=> idx_q == '0);
endmodule

// File: rtl/tps_prbs_gen.sv
module tps_prbs_gen #(
  parameter int unsigned ORDER  = 9,
  parameter int unsigned TAP    = 5,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reseed_i,
  input  logic              advance_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [ORDER-1:0] st_q, st_nxt;

  always_comb begin
    logic [ORDER-1:0] s;
    logic             fb;
    s      = reseed_i ? '1 : st_q;
    byte_o = '0;
    for (int i = 0; i < int'(BYTE_W); i++) begin
      fb                 = s[ORDER-1] ^ s[TAP-1];
      byte_o[BYTE_W-1-i] = fb;
      s                  = {s[ORDER-2:0], fb};
    end
    st_nxt = s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         st_q <= '1;
    else if (advance_i) st_q <= st_nxt;
  end

  // The all-zero lock-up state is never reached
  p_lfsr_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
endmodule

// File: rtl/tx_pattern_src.sv
module tx_pattern_src
  import tps_pkg::*;
#(
  parameter int unsigned PRBS_ORDER = 9,
  parameter int unsigned PRBS_TAP   = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [3:0]              mode_i,
  input  logic [1:0]              pat_sel_i,
  input  logic                    sym_stb_i,
  input  logic [BYTE_W-1:0]       fifo_data_i,
  input  logic                    fifo_valid_i,
  output logic                    fifo_ready_o,
  input  logic                    underrun_clr_i,
  output logic [DIBIT_W-1:0]      dibit_o,
  output logic signed [LVL_W-1:0] level_o,
  output logic                    sym_valid_o,
  output logic                    underrun_o
);
  localparam int unsigned IDX_W  = $clog2(SYM_PER_BYTE);
  localparam int unsigned HOLD_W = BYTE_W - DIBIT_W;

  logic [IDX_W-1:0]        idx_q;
  logic [HOLD_W-1:0]       hold_q;
  logic [3:0]              act_mode_q;
  logic [1:0]              act_sel_q;
  logic [DIBIT_W-1:0]      dibit_q, dibit_nxt;
  logic signed [LVL_W-1:0] level_q, level_nxt;
  logic                    valid_q, underrun_q;

  logic              boundary, stb_bnd, tx_mode, emit_new, emit_mid;
  logic              is_setup, is_prbs, is_data, restart_pat, underrun_ev;
  logic [BYTE_W-1:0] pat_byte, prbs_byte, new_byte;

  always_comb begin
    boundary    = (idx_q == '0);
    stb_bnd     = sym_stb_i && boundary;
    is_setup    = (mode_i == MODE_SETUP);
    is_prbs     = (mode_i == MODE_PRBS);
    is_data     = (mode_i == MODE_DATA);
    tx_mode     = is_setup || is_prbs || is_data;
    restart_pat = (act_mode_q != mode_i) || (act_sel_q != pat_sel_i);
    fifo_ready_o = stb_bnd && is_data;
    underrun_ev = fifo_ready_o && !fifo_valid_i;
    emit_new    = stb_bnd && tx_mode;
    emit_mid    = sym_stb_i && !boundary;
    if (is_setup)          new_byte = pat_byte;
    else if (is_prbs)      new_byte = prbs_byte;
    else if (fifo_valid_i) new_byte = fifo_data_i;
    else                   new_byte = '0;
    dibit_nxt = emit_mid ? hold_q[HOLD_W-1 -: DIBIT_W]
                         : new_byte[BYTE_W-1 -: DIBIT_W];
  end

  tps_pattern_gen #(.BYTE_W(BYTE_W), .IDX_W(3)) u_pat (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (pat_sel_i),
    .restart_i (restart_pat),
    .advance_i (stb_bnd && is_setup),
    .byte_o    (pat_byte)
  );

  tps_prbs_gen #(.ORDER(PRBS_ORDER), .TAP(PRBS_TAP), .BYTE_W(BYTE_W)) u_prbs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reseed_i  (act_mode_q != MODE_PRBS),
    .advance_i (stb_bnd && is_prbs),
    .byte_o    (prbs_byte)
  );

  tps_level_map #(.DIBIT_W(DIBIT_W), .LVL_W(LVL_W)) u_map (
    .dibit_i (dibit_nxt),
    .level_o (level_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      hold_q     <= '0;
      act_mode_q <= MODE_SLEEP;
      act_sel_q  <= '0;
      dibit_q    <= '0;
      level_q    <= '0;
      valid_q    <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      valid_q <= emit_new || emit_mid;
      if (stb_bnd) begin
        act_mode_q <= mode_i;
        act_sel_q  <= pat_sel_i;
      end
      if (emit_new || emit_mid) begin
        dibit_q <= dibit_nxt;
        level_q <= level_nxt;
      end
      if (emit_new) begin
        hold_q <= new_byte[HOLD_W-1:0];
        idx_q  <= underrun_ev ? '0 : IDX_W'(1);
      end else if (emit_mid) begin
        hold_q <= hold_q << DIBIT_W;
        idx_q  <= (idx_q == IDX_W'(SYM_PER_BYTE - 1)) ? '0 : idx_q + 1'b1;
      end
      if (underrun_ev)         underrun_q <= 1'b1;
      else if (underrun_clr_i) underrun_q <= 1'b0;
    end
  end

  assign dibit_o     = dibit_q;
  assign level_o     = level_q;
  assign sym_valid_o = valid_q;
  assign underrun_o  = underrun_q;

  p_valid_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |-> $past(sym_stb_i));

  p_level_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |-> (level_o == (dibit_o == 2'b01 ? 3 : dibit_o == 2'b00 ? 1 :
                                 dibit_o == 2'b10 ? -1 : -3)));

  p_sleep_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb_i && boundary && !tx_mode |=> !sym_valid_o);

  p_ready_on_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready_o |-> sym_stb_i && is_data && idx_q == '0);

  p_underrun_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun_o) |-> sym_valid_o && dibit_o == '0);

  p_underrun_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o && !underrun_clr_i |=> underrun_o);

  p_mode_held_mid_byte_r12: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q != '0 |=> $stable(act_mode_q) && $stable(act_sel_q));
endmodule

// File: tb/tx_pattern_src_tb.sv
module tx_pattern_src_tb_top;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        mode_i = 4'b0000;
  logic [1:0]        pat_sel_i = 2'd0;
  logic              sym_stb_i = 1'b0;
  logic [7:0]        fifo_data_i = 8'h00;
  logic              fifo_valid_i = 1'b0;
  logic              fifo_ready_o;
  logic              underrun_clr_i = 1'b0;
  logic [1:0]        dibit_o;
  logic signed [2:0] level_o;
  logic              sym_valid_o;
  logic              underrun_o;

  int tests = 0;
  int fails = 0;
  logic [1:0] exp_d[$];
  string      exp_r[$];
  logic [7:0] fifo_m[$];
  logic [8:0] lfsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_pattern_src dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pat_sel_i(pat_sel_i),
    .sym_stb_i(sym_stb_i), .fifo_data_i(fifo_data_i), .fifo_valid_i(fifo_valid_i),
    .fifo_ready_o(fifo_ready_o), .underrun_clr_i(underrun_clr_i),
    .dibit_o(dibit_o), .level_o(level_o), .sym_valid_o(sym_valid_o),
    .underrun_o(underrun_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lvl_of(input logic [1:0] d);
    case (d)
      2'b01: return 3;
      2'b00: return 1;
      2'b10: return -1;
      default: return -3;
    endcase
  endfunction

  task automatic push_byte(input logic [7:0] b, input string req);
    for (int k = 3; k >= 0; k--) begin
      exp_d.push_back(b[2*k +: 2]);
      exp_r.push_back(req);
    end
  endtask

  task automatic push_dibit(input logic [1:0] d, input string req);
    exp_d.push_back(d);
    exp_r.push_back(req);
  endtask

  function automatic logic [7:0] prbs_byte();
    logic [7:0] b;
    logic fb;
    for (int k = 7; k >= 0; k--) begin
      fb = lfsr[8] ^ lfsr[4];
      b[k] = fb;
      lfsr = {lfsr[7:0], fb};
    end
    return b;
  endfunction

  task automatic fifo_drive();
    fifo_valid_i = (fifo_m.size() > 0);
    fifo_data_i  = (fifo_m.size() > 0) ? fifo_m[0] : 8'h00;
  endtask

  task automatic strobe(input int n);
    for (int k = 0; k < n; k++) begin
      bit took;
      @(negedge clk);
      sym_stb_i = 1'b1;
      #1;
      took = fifo_ready_o && fifo_valid_i;
      @(posedge clk);
      #1;
      sym_stb_i = 1'b0;
      if (took) void'(fifo_m.pop_front());
      fifo_drive();
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on every presented dibit
  always @(negedge clk) begin
    if (rst_n && sym_valid_o) begin
      if (exp_d.size() == 0) begin
        chk(1'b0, "R2", "unexpected symbol", int'(dibit_o), -1);
      end else begin
        logic [1:0] e;
        string r;
        e = exp_d.pop_front();
        r = exp_r.pop_front();
        chk(dibit_o == e, r, "dibit", int'(dibit_o), int'(e));
        chk(int'(level_o) == lvl_of(dibit_o), "R4", "level", int'(level_o), lvl_of(dibit_o));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog", "timeout", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sym_valid_o == 1'b0, "R1", "valid in reset", int'(sym_valid_o), 0);
    chk(underrun_o == 1'b0, "R1", "underrun in reset", int'(underrun_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fifo_ready_o == 1'b0, "R1", "ready after reset", int'(fifo_ready_o), 0);

    // R2 sleep and a non-transmit code produce nothing
    strobe(4);
    mode_i = 4'b0011;
    strobe(4);

    // R5 pattern 0
    mode_i = 4'b1001; pat_sel_i = 2'd0;
    for (int k = 0; k < 4; k++) push_byte(8'h5F, "R5");
    strobe(16);

    // R6 pattern 1 with wrap
    pat_sel_i = 2'd1;
    for (int k = 0; k < 12; k++) push_byte((k % 8) < 4 ? 8'h55 : 8'hFF, "R6");
    strobe(48);

    // R12 change mid-byte: old byte finishes, new pattern starts at first byte
    pat_sel_i = 2'd3;
    push_byte(8'h7F, "R12");
    strobe(2);
    pat_sel_i = 2'd0;
    push_byte(8'h5F, "R12");
    strobe(6);

    // R8 pattern 3, two loops
    pat_sel_i = 2'd3;
    for (int k = 0; k < 2; k++) begin
      push_byte(8'h7F, "R8"); push_byte(8'h7D, "R8"); push_byte(8'h5D, "R8");
      push_byte(8'hD5, "R8"); push_byte(8'h7D, "R8"); push_byte(8'hFD, "R8");
    end
    strobe(48);

    // R7 pattern 2
    pat_sel_i = 2'd2;
    for (int k = 0; k < 4; k++) push_byte(8'h55, "R7");
    strobe(16);

    // R9 PRBS past the 511-bit wrap
    mode_i = 4'b1010;
    lfsr = 9'h1FF;
    for (int k = 0; k < 66; k++) push_byte(prbs_byte(), "R9");
    strobe(264);

    // R12 leave and re-enter: calibration restarts, PRBS reseeds
    mode_i = 4'b1001;
    push_byte(8'h55, "R12");
    strobe(4);
    mode_i = 4'b1010;
    lfsr = 9'h1FF;
    push_byte(prbs_byte(), "R9"); push_byte(prbs_byte(), "R9");
    strobe(8);

    // R10 preload in sleep: nothing taken
    mode_i = 4'b0000;
    fifo_m.push_back(8'hA5); fifo_m.push_back(8'h3C); fifo_m.push_back(8'h96);
    fifo_drive();
    strobe(4);
    chk(fifo_m.size() == 3, "R10", "fifo kept in sleep", fifo_m.size(), 3);

    // R10 data mode drains in order
    mode_i = 4'b1011;
    push_byte(8'hA5, "R10"); push_byte(8'h3C, "R10"); push_byte(8'h96, "R10");
    strobe(12);
    chk(fifo_m.size() == 0, "R10", "fifo drained", fifo_m.size(), 0);
    chk(underrun_o == 1'b0, "R11", "no underrun yet", int'(underrun_o), 0);

    // R11 underrun fill, sticky flag, resume on boundary
    push_dibit(2'b00, "R11"); push_dibit(2'b00, "R11");
    strobe(2);
    chk(underrun_o == 1'b1, "R11", "underrun set", int'(underrun_o), 1);
    fifo_m.push_back(8'hC3);
    fifo_drive();
    push_byte(8'hC3, "R11");
    strobe(4);
    chk(underrun_o == 1'b1, "R11", "underrun sticky", int'(underrun_o), 1);
    @(negedge clk); underrun_clr_i = 1'b1;
    @(negedge clk); underrun_clr_i = 1'b0;
    chk(underrun_o == 1'b0, "R11", "underrun cleared", int'(underrun_o), 0);

    mode_i = 4'b0000;
    strobe(4);
    chk(exp_d.size() == 0, "R3", "symbols still owed", exp_d.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule